// File: doc/BRIEF.md
# RS-485 Transceiver Direction Controller

This block drives the driver-enable pin of a half-duplex RS-485 transceiver that sits behind a UART transmitter. As soon as the host pushes a character into the transmit FIFO, the pin switches to its asserted level. It stays asserted while characters are shifted out. After the last stop bit of the last queued character, the pin waits for a programmable number of bit periods and then returns to its released level. This gives the line time to settle before another node starts to talk.

The transmitter reports each completed character with a one-cycle `char_done` pulse, and it reports whether its FIFO is empty. A baud generator supplies one `bit_tick` per bit period. An enable bit turns the controller on and off, an invert bit selects the pin polarity, and an 8-bit value sets the hold-off after transmission. Serialization is handled elsewhere.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: When `dir_en` is 1, a cycle with `fifo_wr` = 1 makes `dir_pin` show the asserted level at the next clock edge.
- R2: With `dir_inv` = 0 the asserted level is 0 and the released level is 1. With `dir_inv` = 1 both levels are swapped, so asserted is 1 and released is 0.
- R3: Once asserted, the pin stays asserted until a `char_done` pulse arrives while `fifo_empty` = 1. A `char_done` pulse with `fifo_empty` = 0 does not release the pin, and `bit_tick` pulses before the final `char_done` have no effect.
- R4: After the final `char_done`, the pin is released at the clock edge that samples the N-th `bit_tick`, where N is the value of `hold_bits` (1 to 255).
- R5: When `hold_bits` = 0, the pin is released at the clock edge that samples the final `char_done`.
- R6: A `fifo_wr` during the hold-off cancels the countdown and keeps the pin asserted. When the next final `char_done` arrives, the full `hold_bits` count starts again from zero.
- R7: When `dir_en` = 0, the pin shows the released level and `fifo_wr` is ignored. Clearing `dir_en` during a transmission releases the pin at the next edge.
- R8: While `rst` is high, and after it falls, the controller is idle and `dir_pin` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_en | input | 1 | Direction control enable |
| dir_inv | input | 1 | Pin polarity invert |
| hold_bits | input | DLY_W (8) | Hold-off after the last stop bit, in bit periods |
| fifo_wr | input | 1 | Transmit FIFO write strobe |
| fifo_empty | input | 1 | Transmit FIFO empty flag |
| char_done | input | 1 | One-cycle pulse when a character's stop bit completes |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| dir_pin | output | 1 | Transceiver direction pin (registered) |

## Verification
The main sequence is tried with both polarities and with hold-off values 0, 1, 3, 17, 2 and 255. Each run counts the bit ticks until release, which separates an off-by-one count from a correct one, and the zero case from the nonzero ones. Every run also sends a middle character with the FIFO not empty and a tick during sending. This shows that only the completion with the FIFO empty starts the hold-off, and that early ticks do not count. Further directed cases cover a write during the hold-off that must restart the full count, writes while disabled, disabling during a transmission, and the reset level.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;
  typedef enum logic [1:0] {
    DS_IDLE = 2'd0,
    DS_SEND = 2'd1,
    DS_HOLD = 2'd2
  } dir_state_e;
endpackage

// File: rtl/rs485_hold_cnt.sv
module rs485_hold_cnt #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [DLY_W-1:0] limit,
  output logic             done
);
  localparam int CW = DLY_W + 1;

  logic [DLY_W-1:0] cnt_q;
  logic [CW-1:0]    cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + CW'(1);
  assign done    = run && tick && (cnt_inc >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + DLY_W'(1);
  end

  // Without a tick the elapsed count must hold still during the hold-off.
  AST_CNT_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    (run && !tick && $past(run)) |=> (!run || cnt_q == $past(cnt_q))); // R4
endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
  import rs485_dir_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       wr,
  input  logic       fifo_empty,
  input  logic       char_done,
  input  logic       zero_dly,
  input  logic       hold_done,
  output dir_state_e state_q,
  output dir_state_e state_d
);
  logic last_char;
  assign last_char = char_done && fifo_empty && !wr;

  always_comb begin
    state_d = state_q;
    if (!en) begin
      state_d = DS_IDLE;
    end else begin
      unique case (state_q)
        DS_IDLE: if (wr) state_d = DS_SEND;
        DS_SEND: if (last_char) state_d = zero_dly ? DS_IDLE : DS_HOLD;
        DS_HOLD: begin
          if (wr)             state_d = DS_SEND;
          else if (hold_done) state_d = DS_IDLE;
        end
        default: state_d = DS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= DS_IDLE;
    else     state_q <= state_d;
  end

  AST_SEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (en && state_q == DS_SEND && !(char_done && fifo_empty)) |=> (state_q == DS_SEND)); // R3
  AST_HOLD_CANCEL: assert property (@(posedge clk) disable iff (rst)
    (en && state_q == DS_HOLD && wr) |=> (state_q == DS_SEND)); // R6
  AST_ZERO_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (en && state_q == DS_SEND && char_done && fifo_empty && !wr && zero_dly) |=> (state_q == DS_IDLE)); // R5
endmodule

// File: rtl/rs485_pin_drv.sv
module rs485_pin_drv (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic inv,
  output logic pin
);
  always_ff @(posedge clk) begin
    if (rst) pin <= 1'b1;
    else     pin <= active ? inv : ~inv;
  end

  AST_POLARITY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pin == ($past(active) ? $past(inv) : ~$past(inv)))); // R2
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
  import rs485_dir_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_en,
  input  logic             dir_inv,
  input  logic [DLY_W-1:0] hold_bits,
  input  logic             fifo_wr,
  input  logic             fifo_empty,
  input  logic             char_done,
  input  logic             bit_tick,
  output logic             dir_pin
);
  dir_state_e st_q, st_d;
  logic       hold_done;
  logic       zero_dly;
  logic       in_hold;

  assign zero_dly = (hold_bits == '0);
  assign in_hold  = (st_q == DS_HOLD);

  rs485_dir_fsm u_fsm (
    .clk(clk), .rst(rst), .en(dir_en), .wr(fifo_wr),
    .fifo_empty(fifo_empty), .char_done(char_done),
    .zero_dly(zero_dly), .hold_done(hold_done),
    .state_q(st_q), .state_d(st_d)
  );

  rs485_hold_cnt #(.DLY_W(DLY_W)) u_cnt (
    .clk(clk), .rst(rst), .run(in_hold), .tick(bit_tick),
    .limit(hold_bits), .done(hold_done)
  );

  rs485_pin_drv u_pin (
    .clk(clk), .rst(rst), .active(st_d != DS_IDLE),
    .inv(dir_inv), .pin(dir_pin)
  );

  AST_WR_ASSERTS: assert property (@(posedge clk) disable iff (rst)
    (dir_en && fifo_wr) |=> (dir_pin == $past(dir_inv))); // R1
  AST_DISABLED_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (!dir_en) |=> (dir_pin == ~$past(dir_inv))); // R7
endmodule

// File: tb/rs485_dir_ctrl_test.sv
`timescale 1ns/1ps
module rs485_dir_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dir_en = 1'b0, dir_inv = 1'b0;
  logic [7:0] hold_bits = 8'd0;
  logic       fifo_wr = 1'b0, fifo_empty = 1'b1, char_done = 1'b0, bit_tick = 1'b0;
  logic       dir_pin;
  int         n_run = 0, n_fail = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  rs485_dir_ctrl #(.DLY_W(8)) uut (
    .clk(clk), .rst(rst), .dir_en(dir_en), .dir_inv(dir_inv),
    .hold_bits(hold_bits), .fifo_wr(fifo_wr), .fifo_empty(fifo_empty),
    .char_done(char_done), .bit_tick(bit_tick), .dir_pin(dir_pin)
  );

  // {invert, hold-off, expected ticks to release}
  localparam logic [16:0] VEC [7] = '{
    {1'b0, 8'd0,   8'd0},
    {1'b0, 8'd1,   8'd1},
    {1'b0, 8'd3,   8'd3},
    {1'b1, 8'd2,   8'd2},
    {1'b1, 8'd0,   8'd0},
    {1'b0, 8'd255, 8'd255},
    {1'b1, 8'd17,  8'd17}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_wr();
    fifo_wr = 1'b1; fifo_empty = 1'b0;
    cyc();
    fifo_wr = 1'b0;
  endtask

  task automatic do_char(input bit last);
    char_done = 1'b1; fifo_empty = last;
    cyc();
    char_done = 1'b0;
  endtask

  task automatic count_ticks(output int n);
    n = 0;
    while (dir_pin == dir_inv && n < 400) begin
      bit_tick = 1'b1; cyc(); bit_tick = 1'b0; n++;
      cyc();
    end
  endtask

  initial begin
    int n;
    cyc();
    chk(dir_pin == 1'b1, "R8 pin in reset", dir_pin, 1);
    cyc();
    rst = 1'b0; dir_en = 1'b1;
    cyc();
    chk(dir_pin == 1'b1, "R8 pin after reset", dir_pin, 1);

    for (int i = 0; i < 7; i++) begin
      dir_inv = VEC[i][16]; hold_bits = VEC[i][15:8];
      cyc();
      chk(dir_pin == ~dir_inv, "R2 idle released level", dir_pin, ~dir_inv);
      do_wr();
      chk(dir_pin == dir_inv, "R1 asserted after write", dir_pin, dir_inv);
      do_char(1'b0);
      chk(dir_pin == dir_inv, "R3 held with fifo not empty", dir_pin, dir_inv);
      bit_tick = 1'b1; cyc(); bit_tick = 1'b0;
      do_wr();
      do_char(1'b0);
      do_char(1'b1);
      if (VEC[i][7:0] == 8'd0) begin
        chk(dir_pin == ~dir_inv, "R5 zero hold-off release", dir_pin, ~dir_inv);
      end else begin
        count_ticks(n);
        chk(n == int'(VEC[i][7:0]), "R4 ticks until release", n, VEC[i][7:0]);
      end
    end

    // Write during the hold-off restarts the full count
    dir_inv = 1'b0; hold_bits = 8'd10;
    do_wr(); do_char(1'b1);
    for (int k = 0; k < 4; k++) begin
      bit_tick = 1'b1; cyc(); bit_tick = 1'b0; cyc();
    end
    do_wr();
    chk(dir_pin == 1'b0, "R6 write in hold keeps asserted", dir_pin, 0);
    for (int k = 0; k < 12; k++) begin
      bit_tick = 1'b1; cyc(); bit_tick = 1'b0; cyc();
    end
    chk(dir_pin == 1'b0, "R6 ticks after cancel ignored while sending", dir_pin, 0);
    do_char(1'b1);
    count_ticks(n);
    chk(n == 10, "R6 full count after restart", n, 10);

    // Disabled: writes ignored, pin follows released level
    dir_en = 1'b0;
    do_wr();
    chk(dir_pin == 1'b1, "R7 write ignored when disabled", dir_pin, 1);
    dir_inv = 1'b1; cyc();
    chk(dir_pin == 1'b0, "R7 released level inverted when disabled", dir_pin, 0);
    dir_inv = 1'b0; dir_en = 1'b1;
    do_wr();
    chk(dir_pin == 1'b0, "R1 assert after re-enable", dir_pin, 0);
    dir_en = 1'b0; cyc();
    chk(dir_pin == 1'b1, "R7 disable mid-transfer releases", dir_pin, 1);
    dir_en = 1'b1; do_char(1'b1);
    chk(dir_pin == 1'b1, "R7 no resume after disable", dir_pin, 1);

    // Reset in the middle of sending
    do_wr();
    rst = 1'b1; cyc();
    chk(dir_pin == 1'b1, "R8 reset releases", dir_pin, 1);
    rst = 1'b0; cyc();
    chk(dir_pin == 1'b1, "R8 idle after reset", dir_pin, 1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule